// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock timing of an I2C controller from a fast peripheral clock. It has two stages. A prescaler divides the input clock by one plus a small coarse field and produces a one-cycle internal tick. A phase counter then counts those ticks to shape the serial clock. One full serial clock period is an affine function of a six-bit fine field: a fixed base of 20 ticks, plus 8 ticks per step of the fine field, plus a small compensation term. The compensation term covers bus rise time, fall time and internal delay. Software should pick the coarse field so that the internal tick rate stays below 20 MHz.

Both fields are packed into one configuration word. The coarse field sits in the low bits and the fine field sits directly above it. The width of the coarse field depends on a generation-select parameter. The generator starts with the clock released and then alternates released and driven-low phases. The low phase is half the period, rounded down. The released phase is the remainder, and it is stretched while another device holds the line low. The bus engine gets one-cycle strobes on every falling and rising transition.

Top module: `scl_rate_gen`

## Requirements
- R1: With GEN=1 the configuration word is 9 bits wide. Bits [2:0] are the coarse divider field `cdf` and bits [8:3] are the fine field `scgd`.
- R2: While `enable` is high, `tickOut` pulses for one cycle out of every 1+`cdf` clock cycles.
- R3: The time between consecutive `sclFall` strobes is (20 + 8·`scgd` + `compCycles`)·(1+`cdf`) clock cycles, provided the line is not held low externally.
- R4: The low phase, from `sclFall` to the next `sclRise`, lasts floor(P/2)·(1+`cdf`) cycles, where P = 20 + 8·`scgd` + `compCycles`. The released phase lasts the remaining P − floor(P/2) ticks.
- R5: Take the first clock edge at which `enable` is sampled low. From that edge on, `sclOut` is 1, `sclFall` and `sclRise` stay 0, and `tickOut` is 0, even if a low phase was in progress.
- R6: Let the edge at which `enable` is first sampled high be E. The generator starts in the released phase, and the first `sclFall` appears in the cycle after edge E + (P − floor(P/2))·(1+`cdf`).
- R7: During the released phase, every tick on which `sclIn` is sampled low is not counted, so the phase grows by one tick per such tick. `sclOut` stays 1 throughout.
- R8: With GEN=0 the coarse field is 2 bits wide. The configuration word is 8 bits: `cdf` is bits [1:0] and `scgd` is bits [7:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; low clears both counters and releases the clock |
| cfgWord | input | CDF_W+SCGD_W (9 by default) | Packed configuration: fine field above coarse field |
| compCycles | input | COMP_W (4) | Rise/fall compensation ticks added to the period |
| sclIn | input | 1 | Sensed level of the serial clock line |
| sclOut | output | 1 | 1 = release the line, 0 = drive it low |
| tickOut | output | 1 | One-cycle internal tick |
| sclFall | output | 1 | One-cycle strobe as the generator drives the line low |
| sclRise | output | 1 | One-cycle strobe as the generator releases the line |

## Verification
The bench measures the cycle distance between strobes at the extremes of both fields. A design that placed the fields wrongly, or applied the 8-tick step or the base count incorrectly, would produce intervals that differ from the expected values. It also uses an odd period, which catches a design that rounds the low half up or splits the period evenly. A hold of exactly three ticks during the released phase must lengthen that phase by exactly three ticks: a design that ignored the sensed line, or counted ticks while the line was held, would miss by a whole multiple of the prescale. The bench disables the generator in the middle of a low phase and checks that the line is released at once with no stray strobe. Finally, a second instance built for the narrow generation shows that its word splits two bits lower.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  localparam int BASE_CYCLES = 20;
  localparam int SCGD_STEP   = 8;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } sclState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic dec;
  } phaseCmd_t;

  function automatic int cdfWidth(input int gen);
    return (gen != 0) ? 3 : 2;
  endfunction

endpackage

// File: rtl/scl_rate_dp.sv
module scl_rate_dp
  import scl_rate_pkg::*;
#(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 4,
  parameter int PER_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CDF_W-1:0]  cdf,
  input  logic [SCGD_W-1:0] scgd,
  input  logic [COMP_W-1:0] comp,
  input  phaseCmd_t         cmd,
  output logic              tick,
  output logic              phaseLast
);

  logic [CDF_W-1:0] preCnt;
  logic [PER_W-1:0] perLen;
  logic [PER_W-1:0] lowLen;
  logic [PER_W-1:0] highLen;
  logic [PER_W-1:0] remCnt;

  // stage one: down-counting prescaler, tick on zero
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      preCnt <= '0;
    end else if (preCnt == '0) begin
      preCnt <= cdf;
    end else begin
      preCnt <= preCnt - 1'b1;
    end
  end

  assign tick = enable && (preCnt == '0);

  // stage two: affine period and its split
  always_comb begin
    perLen  = PER_W'(BASE_CYCLES) + PER_W'(scgd) * PER_W'(SCGD_STEP) + PER_W'(comp);
    lowLen  = perLen >> 1;
    highLen = perLen - lowLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      remCnt <= '0;
    end else if (cmd.loadHigh) begin
      remCnt <= highLen;
    end else if (cmd.loadLow) begin
      remCnt <= lowLen;
    end else if (cmd.dec) begin
      remCnt <= remCnt - 1'b1;
    end
  end

  assign phaseLast = (remCnt == PER_W'(1));

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cdf != '0) |=> !tick); // R2
  AST_DEC_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> (remCnt > PER_W'(1))); // R4
  AST_LOAD_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (cmd.loadHigh || cmd.loadLow)) |=> (remCnt >= PER_W'(BASE_CYCLES / 2))); // R3

endmodule

// File: rtl/scl_rate_ctrl.sv
module scl_rate_ctrl
  import scl_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      sclIn,
  input  logic      tick,
  input  logic      phaseLast,
  output phaseCmd_t cmd,
  output logic      sclOut,
  output logic      sclFall,
  output logic      sclRise
);

  sclState_t state;
  sclState_t nextState;

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (!enable) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          nextState    = ST_HIGH;
          cmd.loadHigh = 1'b1;
        end
        ST_HIGH: begin
          if (tick && sclIn) begin
            if (phaseLast) begin
              nextState   = ST_LOW;
              cmd.loadLow = 1'b1;
            end else begin
              cmd.dec = 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            if (phaseLast) begin
              nextState    = ST_HIGH;
              cmd.loadHigh = 1'b1;
            end else begin
              cmd.dec = 1'b1;
            end
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      sclOut  <= 1'b1;
      sclFall <= 1'b0;
      sclRise <= 1'b0;
    end else begin
      state   <= nextState;
      sclOut  <= (nextState != ST_LOW);
      sclFall <= (state != ST_LOW) && (nextState == ST_LOW);
      sclRise <= (state == ST_LOW) && (nextState == ST_HIGH);
    end
  end

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !sclFall && !sclRise)); // R5
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (!sclOut && $past(sclOut))); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sclFall, sclRise})); // R3
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_HIGH && !sclIn) |=> !sclFall); // R7

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int GEN    = 1,
  parameter int SCGD_W = 6,
  parameter int COMP_W = 4,
  localparam int CDF_W = cdfWidth(GEN),
  localparam int CFG_W = CDF_W + SCGD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [COMP_W-1:0] compCycles,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              tickOut,
  output logic              sclFall,
  output logic              sclRise
);

  localparam int MAX_PER = BASE_CYCLES + SCGD_STEP * ((1 << SCGD_W) - 1) + ((1 << COMP_W) - 1);
  localparam int PER_W   = $clog2(MAX_PER + 1);

  logic [CDF_W-1:0]  cdf;
  logic [SCGD_W-1:0] scgd;
  phaseCmd_t         cmd;
  logic              tick;
  logic              phaseLast;

  // fine field packed directly above the coarse field (R1, R8)
  assign cdf  = cfgWord[CDF_W-1:0];
  assign scgd = cfgWord[CFG_W-1:CDF_W];

  scl_rate_dp #(
    .CDF_W (CDF_W),
    .SCGD_W(SCGD_W),
    .COMP_W(COMP_W),
    .PER_W (PER_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .cdf      (cdf),
    .scgd     (scgd),
    .comp     (compCycles),
    .cmd      (cmd),
    .tick     (tick),
    .phaseLast(phaseLast)
  );

  scl_rate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .sclIn    (sclIn),
    .tick     (tick),
    .phaseLast(phaseLast),
    .cmd      (cmd),
    .sclOut   (sclOut),
    .sclFall  (sclFall),
    .sclRise  (sclRise)
  );

  assign tickOut = tick;

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       enable = 1'b0;
  logic [8:0] cfgWord = '0;
  logic [3:0] comp = '0;
  logic       hold = 1'b0;
  logic       sclOut, tick, sclFall, sclRise;
  logic       sclIn;
  assign sclIn = sclOut & ~hold;

  scl_rate_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .compCycles(comp), .sclIn(sclIn), .sclOut(sclOut), .tickOut(tick),
    .sclFall(sclFall), .sclRise(sclRise)
  );

  logic       en0 = 1'b0;
  logic [7:0] cfg0 = '0;
  logic [3:0] comp0 = '0;
  logic       scl0, tick0, fall0, rise0;

  scl_rate_gen #(.GEN(0)) u_dutGen0 (
    .clk(clk), .rstN(rstN), .enable(en0), .cfgWord(cfg0),
    .compCycles(comp0), .sclIn(scl0), .sclOut(scl0), .tickOut(tick0),
    .sclFall(fall0), .sclRise(rise0)
  );

  typedef struct {
    bit    isFall;
    int    delta;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t item;
  int tests = 0;
  int fails = 0;
  int lastStamp = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected strobe intervals as the design produces strobes
  always @(negedge clk) begin
    if (rstN && (sclFall || sclRise)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected strobe", sclFall ? 1 : 2, 0);
      end else begin
        item = expQ.pop_front();
        check(item.isFall == sclFall, {item.req, " strobe kind"}, int'(sclFall), int'(item.isFall));
        check(cyc - lastStamp == item.delta, item.req, cyc - lastStamp, item.delta);
      end
      lastStamp = cyc;
    end
  end

  task automatic pushItem(input bit isFall, input int delta, input string req);
    expItem_t e;
    e.isFall = isFall;
    e.delta  = delta;
    e.req    = req;
    expQ.push_back(e);
  endtask

  // driver: pushes the expected strobe pattern for one configuration
  task automatic pushRun(input int c, input int s, input int r, input int nEvents,
                         input string req);
    int per = 20 + 8 * s + r;
    int lowT = per / 2;
    int highT = per - lowT;
    pushItem(1'b1, 1 + highT * (c + 1), {req, "/R6 first fall"});
    for (int i = 1; i < nEvents; i++) begin
      if (i % 2 == 1) pushItem(1'b0, lowT * (c + 1), {req, "/R4 low phase"});
      else            pushItem(1'b1, highT * (c + 1), {req, "/R3 high phase"});
    end
  endtask

  task automatic startRun(input int c, input int s, input int r);
    @(negedge clk);
    cfgWord = 9'((s << 3) | c);
    comp = 4'(r);
    enable = 1'b1;
    lastStamp = cyc;
  endtask

  task automatic drainAndStop();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclOut == 1'b1, "R5 released after disable", int'(sclOut), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int tickCount;
    int f1, r1, f2, k;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(sclOut == 1'b1, "R5 reset sclOut", int'(sclOut), 1);
    check(!sclFall && !sclRise, "R5 reset strobes", int'({sclFall, sclRise}), 0);
    check(tick == 1'b0, "R5 reset tick", int'(tick), 0);

    // R3 R4 minimum period, no prescale
    pushRun(0, 0, 0, 5, "R3 min");
    startRun(0, 0, 0);
    drainAndStop();

    // R1 field placement, odd period split
    pushRun(3, 2, 5, 4, "R1 word 0x013");
    startRun(3, 2, 5);
    drainAndStop();

    // R1 R3 maximum fields
    pushRun(7, 63, 15, 3, "R1 max fields");
    startRun(7, 63, 15);
    drainAndStop();

    // R2 tick spacing with cdf=5
    startRun(5, 10, 0);
    tickCount = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) tickCount++;
    end
    check(tickCount == 10, "R2 ticks in 60 cycles", tickCount, 10);
    enable = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R5 tick off when disabled", int'(tick), 0);
    repeat (3) @(negedge clk);

    // R7 stretch by three ticks (cdf=1)
    pushItem(1'b1, 21, "R7/R6 first fall");
    pushItem(1'b0, 20, "R7 low phase");
    pushItem(1'b1, 26, "R7 stretched high phase");
    pushItem(1'b0, 20, "R7 low after stretch");
    startRun(1, 0, 0);
    do @(negedge clk); while (!sclRise);
    hold = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(sclOut == 1'b1, "R7 sclOut released while held", int'(sclOut), 1);
    end
    hold = 1'b0;
    drainAndStop();

    // R5 disable in the middle of a low phase
    pushItem(1'b1, 11, "R5/R6 first fall");
    startRun(0, 0, 0);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(sclOut == 1'b0, "R5 low phase in progress", int'(sclOut), 0);
    enable = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(sclOut == 1'b1 && tick == 1'b0, "R5 idle after mid-low disable",
            int'({sclOut, tick}), 2);
    end

    // R8 narrow generation: word 0x07 -> cdf=3, scgd=1, P=30
    @(negedge clk);
    cfg0 = 8'h07;
    comp0 = 4'd2;
    en0 = 1'b1;
    k = cyc;
    do @(negedge clk); while (!fall0);
    f1 = cyc;
    do @(negedge clk); while (!rise0);
    r1 = cyc;
    do @(negedge clk); while (!fall0);
    f2 = cyc;
    check(f1 - k == 61, "R8 first fall", f1 - k, 61);
    check(r1 - f1 == 60, "R8 low phase", r1 - f1, 60);
    check(f2 - f1 == 120, "R8 period", f2 - f1, 120);
    en0 = 1'b0;
    repeat (3) @(negedge clk);

    finishRun();
  end

endmodule